// File: doc/BRIEF.md
# Network controller command and status register block

This block is the host-facing control register set of a network controller. Software writes a 16-bit command word that holds two independent opcodes: one for the transmit/command engine and one for the receive engine. Each opcode stays visible in the register until its engine takes it with a one-cycle accept pulse. The field then reads as zero, so software can poll the command word to find out when the next command may be issued. A 32-bit general pointer register supplies the operand for each command. The pointer value is copied to the engine that takes the command, on the same edge as the accept.

A 16-bit status word reports the state of both engines and a set of event flags. Software acknowledges the event flags by writing ones to them. An interrupt control byte holds a mask bit and a software interrupt request. The interrupt output combines the pending events with that request. The engines themselves are outside the block; they connect through accept pulses, state fields and event pulses.

Top module: `nic_ctl_regs`

## Requirements
- R1: After reset, both words read as zero (with all state inputs at zero), both opcode outputs are 0, both pointer outputs are 0 and irq_o is low.
- R2: Word 0 (byte address 0) bits 23:20 hold the command-engine opcode. Codes 1, 2, 4, 5, 6 and 7 are stored, presented on cu_cmd_o and read back until accepted.
- R3: Word 0 bits 18:16 hold the receive-engine opcode. Codes 1, 2, 4, 6 and 7 are stored, presented on ru_cmd_o and read back until accepted. Bit 19 reads as 0.
- R4: Writing code 0 or an undefined code (command 3 or 8..15, receive 3 or 5) leaves that opcode field unchanged. This lets one engine be commanded without disturbing the other's pending opcode.
- R5: An accept pulse while its field is nonzero clears only that field. On the same edge it copies the pointer register to that engine's pointer output. An accept pulse while the field is zero changes nothing.
- R6: When a command write and an accept for the same field land on the same edge, the newly written opcode stays pending. The pointer is still copied.
- R7: Status bits 15:8 are event flags set by evt_set_i[7:0]. Bit 9 never sets. A write with byte enable 1 clears each flag whose data bit is 1. Data bits of 0, or a write without byte enable 1, leave the flags unchanged.
- R8: An event set and an acknowledge of the same flag on the same edge leave the flag set.
- R9: irq_o is high when any event flag is set and the mask (word 0 bit 24) is 0. When the mask is 1, the event flags do not drive irq_o.
- R10: Writing 1 to word 0 bit 25 stores a software interrupt request that reads back and also sets event bit 10. While the request is stored, irq_o is high regardless of the mask. Writing 0 to bit 25 withdraws the request.
- R11: Word 1 (byte address 4) is the 32-bit pointer register. It is written per byte lane under bus_be_i and reads back.
- R12: Status bits 7:6 mirror cu_state_i and bits 5:2 mirror ru_state_i (receive codes: 0 idle, 1 suspended, 2 no resources, 4 ready, plus 8 for no buffer descriptors). Bits 1:0 read 0. Writes to byte 0 have no effect.
- R13: Word addresses other than 0 and 1 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | AW | Byte address; bits AW-1:2 select the word |
| bus_we_i | input | 1 | Write strobe |
| bus_be_i | input | 4 | Byte lane enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed word (combinational) |
| evt_set_i | input | 8 | Event pulses for status bits 15:8 |
| cu_state_i | input | 2 | Command engine state |
| ru_state_i | input | 4 | Receive engine state |
| cu_cmd_o | output | 4 | Pending command-engine opcode, 0 when none |
| cu_ptr_o | output | 32 | Pointer copied at the last command-engine accept |
| cu_accept_i | input | 1 | Command engine takes its opcode |
| ru_cmd_o | output | 3 | Pending receive-engine opcode, 0 when none |
| ru_ptr_o | output | 32 | Pointer copied at the last receive-engine accept |
| ru_accept_i | input | 1 | Receive engine takes its opcode |
| irq_o | output | 1 | Interrupt request |

## Verification
Every register update takes one cycle. A write, accept or event pulse presented before a rising edge is visible on the opcode outputs, the pointer outputs, irq_o and the read data just after that edge. The state mirror in status bits 7:2 and the read path add no delay. The bench drives each stimulus just after a falling edge and holds it across exactly one rising edge. It samples results at the next falling edge, which is the first point where the registered value is due. Read data is sampled a short delay after the address settles within the same low phase.

// File: rtl/nic_ctl_pkg.sv
package nic_ctl_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int CU_W   = 4;
  localparam int RU_W   = 3;
  localparam int EVT_W  = 8;

  // opcode codes that may enter the slots (code 0 never does)
  localparam logic [(1<<CU_W)-1:0] CU_LEGAL = 16'h00F6;
  localparam logic [(1<<RU_W)-1:0] RU_LEGAL = 8'hD6;
  // status high byte: bit 1 (status bit 9) is reserved
  localparam logic [EVT_W-1:0] EVT_LIVE = 8'hFD;
  localparam int EVT_SWI = 2;

  // word 0 field positions
  localparam int POS_EVT  = 8;
  localparam int POS_RU   = 16;
  localparam int POS_CU   = 20;
  localparam int POS_MASK = 24;
  localparam int POS_SWI  = 25;
endpackage

// File: rtl/nic_bus_dec.sv
module nic_bus_dec
  import nic_ctl_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] word0_i,
  input  logic [DATA_W-1:0] word1_i,
  output logic              w0_we_o,
  output logic              w1_we_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = AW - 2;

  logic [IDX_W-1:0] idx;
  logic sel0, sel1;
  logic unused_lsb;

  assign idx        = addr_i[AW-1:2];
  assign unused_lsb = ^addr_i[1:0];
  assign sel0       = (idx == IDX_W'(0));
  assign sel1       = (idx == IDX_W'(1));
  assign w0_we_o    = we_i && sel0;
  assign w1_we_o    = we_i && sel1;

  always_comb begin
    rdata_o = '0;
    if (sel0)      rdata_o = word0_i;
    else if (sel1) rdata_o = word1_i;
  end
endmodule

// File: rtl/nic_evt_bank.sv
module nic_evt_bank #(
  parameter int          N    = 8,
  parameter logic [N-1:0] LIVE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;  // set wins over clear
        else if (clr_i[i]) q <= 1'b0;
      end
      assign q_o[i] = q;
    end else begin : g_tie
      logic unused_in;
      assign unused_in = set_i[i] ^ clr_i[i];
      assign q_o[i]    = 1'b0;
    end
  end
endmodule

// File: rtl/nic_opc_slot.sv
module nic_opc_slot #(
  parameter int                 W     = 4,
  parameter int                 PW    = 32,
  parameter logic [(1<<W)-1:0]  LEGAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [W-1:0]  code_i,
  input  logic [PW-1:0] ptr_i,
  input  logic          accept_i,
  output logic [W-1:0]  code_o,
  output logic [PW-1:0] ptr_o
);
  logic [W-1:0]  code_q;
  logic [PW-1:0] ptr_q;
  logic take, load;

  assign take = accept_i && (code_q != '0);
  assign load = wr_i && LEGAL[code_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (take) begin
        code_q <= '0;
        ptr_q  <= ptr_i;
      end
      if (load) code_q <= code_i;  // fresh write stays pending
    end
  end

  assign code_o = code_q;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/nic_ctl_regs.sv
module nic_ctl_regs
  import nic_ctl_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_we_i,
  input  logic [BE_W-1:0]   bus_be_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [EVT_W-1:0]  evt_set_i,
  input  logic [1:0]        cu_state_i,
  input  logic [3:0]        ru_state_i,
  output logic [CU_W-1:0]   cu_cmd_o,
  output logic [DATA_W-1:0] cu_ptr_o,
  input  logic              cu_accept_i,
  output logic [RU_W-1:0]   ru_cmd_o,
  output logic [DATA_W-1:0] ru_ptr_o,
  input  logic              ru_accept_i,
  output logic              irq_o
);
  logic              w0_we, w1_we, cmd_wr, ctl_wr, ack_wr, swi_set;
  logic [DATA_W-1:0] word0, word1, ptr_q;
  logic [EVT_W-1:0]  evt_q, evt_set, evt_clr;
  logic              mask_q, swi_q;
  logic              unused_wd;

  nic_bus_dec #(.AW(AW)) u_dec (
    .addr_i (bus_addr_i),
    .we_i   (bus_we_i),
    .word0_i(word0),
    .word1_i(word1),
    .w0_we_o(w0_we),
    .w1_we_o(w1_we),
    .rdata_o(bus_rdata_o)
  );

  assign ack_wr  = w0_we && bus_be_i[1];
  assign cmd_wr  = w0_we && bus_be_i[2];
  assign ctl_wr  = w0_we && bus_be_i[3];
  assign swi_set = ctl_wr && bus_wdata_i[POS_SWI];

  // pointer register, per byte lane
  for (genvar b = 0; b < BE_W; b++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  ptr_q[8*b +: 8] <= '0;
      else if (w1_we && bus_be_i[b]) ptr_q[8*b +: 8] <= bus_wdata_i[8*b +: 8];
    end
  end

  nic_opc_slot #(.W(CU_W), .PW(DATA_W), .LEGAL(CU_LEGAL)) u_cu_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cmd_wr),
    .code_i  (bus_wdata_i[POS_CU +: CU_W]),
    .ptr_i   (ptr_q),
    .accept_i(cu_accept_i),
    .code_o  (cu_cmd_o),
    .ptr_o   (cu_ptr_o)
  );

  nic_opc_slot #(.W(RU_W), .PW(DATA_W), .LEGAL(RU_LEGAL)) u_ru_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cmd_wr),
    .code_i  (bus_wdata_i[POS_RU +: RU_W]),
    .ptr_i   (ptr_q),
    .accept_i(ru_accept_i),
    .code_o  (ru_cmd_o),
    .ptr_o   (ru_ptr_o)
  );

  always_comb begin
    evt_set = evt_set_i;
    evt_set[EVT_SWI] = evt_set_i[EVT_SWI] | swi_set;
    evt_clr = ack_wr ? bus_wdata_i[POS_EVT +: EVT_W] : '0;
  end

  nic_evt_bank #(.N(EVT_W), .LIVE(EVT_LIVE)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_set),
    .clr_i (evt_clr),
    .q_o   (evt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b0;
      swi_q  <= 1'b0;
    end else if (ctl_wr) begin
      mask_q <= bus_wdata_i[POS_MASK];
      swi_q  <= bus_wdata_i[POS_SWI];
    end
  end

  assign irq_o = ((|evt_q) && !mask_q) || swi_q;

  assign word0 = {6'b0, swi_q, mask_q,
                  cu_cmd_o, 1'b0, ru_cmd_o,
                  evt_q,
                  cu_state_i, ru_state_i, 2'b00};
  assign word1 = ptr_q;

  assign unused_wd = ^{bus_wdata_i[31:26], bus_wdata_i[19], bus_wdata_i[7:0]};
endmodule

// File: rtl/nic_ctl_regs_chk.sv
module nic_ctl_regs_chk
  import nic_ctl_pkg::*;
#(
  parameter int AW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     bus_addr_i,
  input logic              bus_we_i,
  input logic [BE_W-1:0]   bus_be_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [EVT_W-1:0]  evt_set_i,
  input logic [CU_W-1:0]   cu_cmd_o,
  input logic [DATA_W-1:0] cu_ptr_o,
  input logic              cu_accept_i,
  input logic [RU_W-1:0]   ru_cmd_o,
  input logic [DATA_W-1:0] ru_ptr_o,
  input logic              ru_accept_i,
  input logic              irq_o,
  input logic [EVT_W-1:0]  evt_q,
  input logic              mask_q,
  input logic              swi_q
);
  logic cmd_wr;
  assign cmd_wr = bus_we_i && (bus_addr_i[AW-1:2] == '0) && bus_be_i[2];

  a_r4_cu_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cu_cmd_o == '0) || CU_LEGAL[cu_cmd_o]);
  a_r4_ru_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ru_cmd_o == '0) || RU_LEGAL[ru_cmd_o]);
  a_r5_cu_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cu_accept_i && cu_cmd_o != '0 && !cmd_wr) |=> cu_cmd_o == '0);
  a_r5_ru_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ru_accept_i && ru_cmd_o != '0 && !cmd_wr) |=> ru_cmd_o == '0);
  a_r5_cu_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cu_accept_i && cu_cmd_o != '0) |=> $stable(cu_ptr_o));
  a_r5_ru_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ru_accept_i && ru_cmd_o != '0) |=> $stable(ru_ptr_o));
  a_r6_cu_wr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && CU_LEGAL[bus_wdata_i[POS_CU +: CU_W]])
      |=> cu_cmd_o == $past(bus_wdata_i[POS_CU +: CU_W]));
  a_r7_bit9_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q[1] == 1'b0);
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_set_i[7] |=> evt_q[7]);
  a_r9_mask_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q && !swi_q) |-> !irq_o);
  a_r9_evt_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_set_i & EVT_LIVE) != '0 && !mask_q && !(bus_we_i && bus_be_i[3]))
      |=> irq_o);
  a_r10_swi_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swi_q |-> irq_o);
endmodule

bind nic_ctl_regs nic_ctl_regs_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_addr_i (bus_addr_i),
  .bus_we_i   (bus_we_i),
  .bus_be_i   (bus_be_i),
  .bus_wdata_i(bus_wdata_i),
  .evt_set_i  (evt_set_i),
  .cu_cmd_o   (cu_cmd_o),
  .cu_ptr_o   (cu_ptr_o),
  .cu_accept_i(cu_accept_i),
  .ru_cmd_o   (ru_cmd_o),
  .ru_ptr_o   (ru_ptr_o),
  .ru_accept_i(ru_accept_i),
  .irq_o      (irq_o),
  .evt_q      (evt_q),
  .mask_q     (mask_q),
  .swi_q      (swi_q)
);

// File: tb/nic_ctl_regs_bench.sv
module nic_ctl_regs_bench;
  localparam int AW = 5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic        bus_we_i = 1'b0;
  logic [3:0]  bus_be_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [7:0]  evt_set_i = '0;
  logic [1:0]  cu_state_i = '0;
  logic [3:0]  ru_state_i = '0;
  logic [3:0]  cu_cmd_o;
  logic [31:0] cu_ptr_o;
  logic        cu_accept_i = 1'b0;
  logic [2:0]  ru_cmd_o;
  logic [31:0] ru_ptr_o;
  logic        ru_accept_i = 1'b0;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  nic_ctl_regs #(.AW(AW)) u_nic_ctl_regs (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_be_i(bus_be_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .evt_set_i(evt_set_i), .cu_state_i(cu_state_i), .ru_state_i(ru_state_i),
    .cu_cmd_o(cu_cmd_o), .cu_ptr_o(cu_ptr_o), .cu_accept_i(cu_accept_i),
    .ru_cmd_o(ru_cmd_o), .ru_ptr_o(ru_ptr_o), .ru_accept_i(ru_accept_i),
    .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // drive after falling edge, held over one rising edge, ends at next falling edge
  task automatic wr(logic [AW-1:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_addr_i = a; bus_be_i = be; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk);
    bus_we_i = 1'b0; bus_be_i = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #0.5;
    d = bus_rdata_o;
  endtask

  task automatic pulse(logic cu, logic ru, logic [7:0] ev);
    @(negedge clk);
    cu_accept_i = cu; ru_accept_i = ru; evt_set_i = ev;
    @(negedge clk);
    cu_accept_i = 1'b0; ru_accept_i = 1'b0; evt_set_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); chk("R1 word0", d, 0);
    rd(4, d); chk("R1 word1", d, 0);
    chk("R1 cu_cmd", 32'(cu_cmd_o), 0);
    chk("R1 ru_cmd", 32'(ru_cmd_o), 0);
    chk("R1 cu_ptr", cu_ptr_o, 0);
    chk("R1 ru_ptr", ru_ptr_o, 0);
    chk("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_ptr();
    logic [31:0] d;
    wr(4, 4'hF, 32'h1234_5678);
    rd(4, d); chk("R11 full write", d, 32'h1234_5678);
    wr(4, 4'b0010, 32'hAAAA_AAAA);
    rd(4, d); chk("R11 lane 1 write", d, 32'h1234_AA78);
  endtask

  task automatic t_state();
    logic [31:0] d;
    @(negedge clk);
    cu_state_i = 2'b10; ru_state_i = 4'b1010;
    rd(0, d); chk("R12 state mirror", d & 32'hFF, 32'hA8);
    wr(0, 4'b0001, 32'h0000_00FF);
    rd(0, d); chk("R12 byte0 write ignored", d & 32'hFF, 32'hA8);
    cu_state_i = '0; ru_state_i = '0;
  endtask

  task automatic t_cu();
    logic [31:0] d;
    wr(4, 4'hF, 32'hC0DE_0001);
    wr(0, 4'b0100, 32'h0010_0000);
    rd(0, d); chk("R2 readback pending", d & 32'h00FF_0000, 32'h0010_0000);
    chk("R2 cu_cmd start", 32'(cu_cmd_o), 1);
    chk("R3 ru untouched", 32'(ru_cmd_o), 0);
    pulse(1'b1, 1'b0, 8'h00);
    chk("R5 cu cleared", 32'(cu_cmd_o), 0);
    rd(0, d); chk("R5 readback zero", d & 32'h00FF_0000, 0);
    chk("R5 cu ptr copied", cu_ptr_o, 32'hC0DE_0001);
    chk("R5 ru ptr unchanged", ru_ptr_o, 0);
  endtask

  task automatic t_ru();
    logic [31:0] d;
    wr(4, 4'hF, 32'h0000_BEEF);
    wr(0, 4'b0100, 32'h0024_0000);
    chk("R3 ru abort", 32'(ru_cmd_o), 4);
    chk("R2 cu resume", 32'(cu_cmd_o), 2);
    pulse(1'b0, 1'b1, 8'h00);
    chk("R5 ru cleared", 32'(ru_cmd_o), 0);
    chk("R5 cu kept", 32'(cu_cmd_o), 2);
    chk("R5 ru ptr copied", ru_ptr_o, 32'h0000_BEEF);
    chk("R5 cu ptr kept", cu_ptr_o, 32'hC0DE_0001);
    wr(0, 4'b0100, 32'h0007_0000);
    chk("R4 nop keeps cu", 32'(cu_cmd_o), 2);
    rd(0, d); chk("R3 ru 7 readback", d & 32'h000F_0000, 32'h0007_0000);
    pulse(1'b1, 1'b1, 8'h00);
  endtask

  task automatic t_illegal();
    wr(0, 4'b0100, 32'h0050_0000);
    wr(0, 4'b0100, 32'h0030_0000);
    chk("R4 cu code 3 dropped", 32'(cu_cmd_o), 5);
    wr(0, 4'b0100, 32'h00F0_0000);
    chk("R4 cu code 15 dropped", 32'(cu_cmd_o), 5);
    wr(0, 4'b0100, 32'h0005_0000);
    chk("R4 ru code 5 dropped", 32'(ru_cmd_o), 0);
    wr(0, 4'b0100, 32'h0003_0000);
    chk("R4 ru code 3 dropped", 32'(ru_cmd_o), 0);
    wr(4, 4'hF, 32'h5555_0000);
    pulse(1'b0, 1'b1, 8'h00);
    chk("R5 idle accept keeps ptr", ru_ptr_o, 32'h0000_BEEF);
  endtask

  task automatic t_race();
    @(negedge clk);
    bus_addr_i = 0; bus_be_i = 4'b0100; bus_wdata_i = 32'h0010_0000; bus_we_i = 1'b1;
    cu_accept_i = 1'b1;
    @(negedge clk);
    bus_we_i = 1'b0; bus_be_i = '0; cu_accept_i = 1'b0;
    chk("R6 new opcode pending", 32'(cu_cmd_o), 1);
    chk("R6 ptr copied", cu_ptr_o, 32'h5555_0000);
    pulse(1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse(1'b0, 1'b0, 8'hFF);
    rd(0, d); chk("R7 events set, bit9 stays 0", d & 32'hFF00, 32'hFD00);
    chk("R9 irq from events", 32'(irq_o), 1);
    wr(0, 4'b0010, 32'h0000_8100);
    rd(0, d); chk("R7 w1c selected", d & 32'hFF00, 32'h7C00);
    wr(0, 4'b0001, 32'h0000_FF00);
    rd(0, d); chk("R7 no lane enable", d & 32'hFF00, 32'h7C00);
    wr(0, 4'b0010, 32'h0000_0000);
    rd(0, d); chk("R7 zeros ignored", d & 32'hFF00, 32'h7C00);
    wr(0, 4'b0010, 32'h0000_FF00);
    rd(0, d); chk("R7 all cleared", d & 32'hFF00, 0);
    chk("R9 irq drops", 32'(irq_o), 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    pulse(1'b0, 1'b0, 8'h80);
    @(negedge clk);
    bus_addr_i = 0; bus_be_i = 4'b0010; bus_wdata_i = 32'h0000_8000; bus_we_i = 1'b1;
    evt_set_i = 8'h80;
    @(negedge clk);
    bus_we_i = 1'b0; bus_be_i = '0; evt_set_i = '0;
    rd(0, d); chk("R8 set beats clear", d & 32'hFF00, 32'h8000);
    wr(0, 4'b0010, 32'h0000_8000);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(0, 4'b1000, 32'h0100_0000);
    pulse(1'b0, 1'b0, 8'h40);
    rd(0, d); chk("R9 event recorded while masked", d & 32'hFF00, 32'h4000);
    chk("R9 masked irq low", 32'(irq_o), 0);
    wr(0, 4'b1000, 32'h0000_0000);
    chk("R9 unmasked irq high", 32'(irq_o), 1);
    wr(0, 4'b0010, 32'h0000_4000);
    chk("R9 acked irq low", 32'(irq_o), 0);
  endtask

  task automatic t_swi();
    logic [31:0] d;
    wr(0, 4'b1000, 32'h0200_0000);
    rd(0, d); chk("R10 swi readback and event", d & 32'h0300_FF00, 32'h0200_0400);
    chk("R10 irq", 32'(irq_o), 1);
    wr(0, 4'b1000, 32'h0300_0000);
    chk("R10 irq despite mask", 32'(irq_o), 1);
    wr(0, 4'b0010, 32'h0000_0400);
    rd(0, d); chk("R10 event acked", d & 32'hFF00, 0);
    chk("R10 request still drives irq", 32'(irq_o), 1);
    wr(0, 4'b1000, 32'h0000_0000);
    chk("R10 withdrawn", 32'(irq_o), 0);
  endtask

  task automatic t_hole();
    logic [31:0] d;
    wr(8, 4'hF, 32'hFFFF_FFFF);
    rd(8, d);  chk("R13 hole reads zero", d, 0);
    rd(0, d);  chk("R13 word0 untouched", d, 0);
    rd(4, d);  chk("R13 word1 untouched", d, 32'h5555_0000);
    wr(28, 4'hF, 32'hFFFF_FFFF);
    chk("R13 no opcode from hole", 32'({cu_cmd_o, ru_cmd_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_ptr();
    t_state();
    t_cu();
    t_ru();
    t_illegal();
    t_race();
    t_events();
    t_set_wins();
    t_mask();
    t_swi();
    t_hole();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule